// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the register store of a 32-bit processor core. It shows sixteen architectural registers (index 0 to 15) and a current status word. Which physical register an index reaches depends on the processor mode held in the low three bits of the status word. Behind that view sit 37 physical 32-bit registers: 31 general registers and 6 status registers. Registers 0 to 7 and the program counter at index 15 are common to every mode. Each exception mode has its own stack pointer (index 13) and link register (index 14). The fast interrupt mode also has its own indices 8 to 12, so its handlers never have to save those registers.

Two combinational read ports and one clocked write port serve the general registers. The program counter is loaded only through its own port. Separate ports load the status word and give access to the saved-status register of the current mode. Each of the five exception modes has one saved-status register. User and system mode have none. A user-bank override lets privileged code reach the user copies of indices 8 to 14.

Top module: `bankedRegFile`

## Requirements
- R1: After reset every general register, the program counter and every saved-status register read zero. The status word reads 0x00000003 (supervisor mode).
- R2: The mode is the status word bits [2:0]: 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 6 system, 7 reserved. `curMode` shows that field. A status-word write takes effect at the next clock edge.
- R3: Indices 0 to 7 reach the same storage in every mode.
- R4: Modes 1 to 5 each have a private copy of indices 13 and 14. System mode uses the user copies.
- R5: In mode 1, indices 8 to 12 reach private copies. Every other mode uses the user copies of indices 8 to 12.
- R6: Modes 1 to 5 each have a private saved-status register. In modes 0, 6 and 7 the saved-status port reads zero and a write to it is ignored.
- R7: While `userBank` is high, indices 8 to 14 read and write the user copies in any mode.
- R8: A general-port write to index 15 is ignored. `pcWe` loads the program counter at the clock edge. Index 15 and `pcOut` both show the program counter.
- R9: A read of an index written in the same cycle returns the old value. The new value appears after the clock edge.
- R10: The two read ports are independent and return equal data for equal indices.
- R11: Reserved mode 7 reaches the same registers as user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdIdxA | input | 4 | Read port A index |
| rdDataA | output | 32 | Read port A data |
| rdIdxB | input | 4 | Read port B index |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | General write enable |
| wrIdx | input | 4 | General write index |
| wrData | input | 32 | General write data |
| userBank | input | 1 | Force indices 8 to 14 to the user copies |
| pcWe | input | 1 | Program counter write enable |
| pcWdata | input | 32 | Program counter write data |
| pcOut | output | 32 | Program counter |
| statWe | input | 1 | Status word write enable |
| statWdata | input | 32 | Status word write data |
| statRdata | output | 32 | Status word |
| savedWe | input | 1 | Saved-status write enable |
| savedWdata | input | 32 | Saved-status write data |
| savedRdata | output | 32 | Saved-status register of the current mode |
| curMode | output | 3 | Current mode field |

## Verification
The assertions check the port-level rules on every cycle:
- the program counter ignores general writes and follows its own port;
- the status word loads on a write;
- the saved-status port reads zero in modes without one;
- a written register shows its new value one cycle later;
- the two read ports agree on equal indices.

Only the directed scenarios can show the bank separation. That means a value written in one mode stays hidden or stays visible when the bench later switches to another mode. The same applies to the user-bank override and to reserved mode falling back to the user bank.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;
  localparam int IDX_W   = 4;
  localparam int NUM_GPR = 31;
  localparam int SLOT_W  = 5;
  localparam int NUM_SAV = 5;
  localparam int SAV_W   = 3;
  localparam int PC_SLOT = 15;
  localparam logic [SLOT_W-1:0] FAST_BASE = 5'd16;
  localparam logic [SLOT_W-1:0] PRIV_BASE = 5'd23;

  typedef enum logic [2:0] {
    MODE_USER   = 3'd0,
    MODE_FAST   = 3'd1,
    MODE_IRQ    = 3'd2,
    MODE_SUPV   = 3'd3,
    MODE_ABORT  = 3'd4,
    MODE_UNDEF  = 3'd5,
    MODE_SYSTEM = 3'd6,
    MODE_RSVD   = 3'd7
  } mode_e;

  typedef struct packed {
    logic              gprWe;
    logic [SLOT_W-1:0] gprSlot;
    logic [SLOT_W-1:0] rdSlotA;
    logic [SLOT_W-1:0] rdSlotB;
    logic              savedHit;
    logic              savedWr;
    logic [SAV_W-1:0]  savedSlot;
  } rf_strobe_t;
endpackage

// File: rtl/bankrf_ctrl.sv
module bankrf_ctrl
  import bankrf_pkg::*;
(
  input  logic [2:0]       curMode,
  input  logic             userBank,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             savedWe,
  output rf_strobe_t       strobe
);
  function automatic logic [SLOT_W-1:0] slotOf(input logic [IDX_W-1:0] idx,
                                                input logic [2:0] mode,
                                                input logic useUser);
    logic [SLOT_W-1:0] s;
    logic [SLOT_W-1:0] ext;
    ext = {1'b0, idx};
    s   = ext;
    if (!useUser) begin
      if (mode == MODE_FAST && idx >= 4'd8 && idx <= 4'd14) begin
        s = FAST_BASE + ext - 5'd8;
      end else if (idx == 4'd13 || idx == 4'd14) begin
        case (mode)
          MODE_IRQ:   s = PRIV_BASE + 5'd0 + ext - 5'd13;
          MODE_SUPV:  s = PRIV_BASE + 5'd2 + ext - 5'd13;
          MODE_ABORT: s = PRIV_BASE + 5'd4 + ext - 5'd13;
          MODE_UNDEF: s = PRIV_BASE + 5'd6 + ext - 5'd13;
          default:    s = ext;
        endcase
      end
    end
    return s;
  endfunction

  logic hasSaved;
  assign hasSaved = (curMode >= 3'd1) && (curMode <= 3'd5);

  always_comb begin
    strobe           = '0;
    strobe.gprWe     = wrEn && (wrIdx != 4'(PC_SLOT));
    strobe.gprSlot   = slotOf(wrIdx, curMode, userBank);
    strobe.rdSlotA   = slotOf(rdIdxA, curMode, userBank);
    strobe.rdSlotB   = slotOf(rdIdxB, curMode, userBank);
    strobe.savedHit  = hasSaved;
    strobe.savedWr   = hasSaved && savedWe;
    strobe.savedSlot = hasSaved ? (curMode - 3'd1) : '0;
  end
endmodule

// File: rtl/bankrf_datapath.sv
module bankrf_datapath
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rf_strobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcWe,
  input  logic [DATA_W-1:0] pcWdata,
  input  logic              statWe,
  input  logic [DATA_W-1:0] statWdata,
  input  logic [DATA_W-1:0] savedWdata,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] statRdata,
  output logic [DATA_W-1:0] savedRdata,
  output logic [2:0]        curMode
);
  localparam logic [DATA_W-1:0] STAT_RESET = DATA_W'(MODE_SUPV);

  logic [DATA_W-1:0] gpr   [NUM_GPR];
  logic [DATA_W-1:0] saved [NUM_SAV];
  logic [DATA_W-1:0] statReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_GPR; i++) gpr[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_GPR; i++) begin
        if (i == PC_SLOT) begin
          if (pcWe) gpr[i] <= pcWdata;
        end else if (strobe.gprWe && strobe.gprSlot == SLOT_W'(i)) begin
          gpr[i] <= wrData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SAV; i++) saved[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SAV; i++) begin
        if (strobe.savedWr && strobe.savedSlot == SAV_W'(i)) saved[i] <= savedWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       statReg <= STAT_RESET;
    else if (statWe) statReg <= statWdata;
  end

  assign rdDataA    = gpr[strobe.rdSlotA];
  assign rdDataB    = gpr[strobe.rdSlotB];
  assign pcOut      = gpr[PC_SLOT];
  assign statRdata  = statReg;
  assign curMode    = statReg[2:0];
  assign savedRdata = strobe.savedHit ? saved[strobe.savedSlot] : '0;
endmodule

// File: rtl/bankedRegFile.sv
module bankedRegFile
  import bankrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              userBank,
  input  logic              pcWe,
  input  logic [DATA_W-1:0] pcWdata,
  output logic [DATA_W-1:0] pcOut,
  input  logic              statWe,
  input  logic [DATA_W-1:0] statWdata,
  output logic [DATA_W-1:0] statRdata,
  input  logic              savedWe,
  input  logic [DATA_W-1:0] savedWdata,
  output logic [DATA_W-1:0] savedRdata,
  output logic [2:0]        curMode
);
  rf_strobe_t strobe;

  bankrf_ctrl ctrl_i (
    .curMode(curMode), .userBank(userBank), .rdIdxA(rdIdxA), .rdIdxB(rdIdxB),
    .wrEn(wrEn), .wrIdx(wrIdx), .savedWe(savedWe), .strobe(strobe)
  );

  bankrf_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .pcWe(pcWe), .pcWdata(pcWdata), .statWe(statWe), .statWdata(statWdata),
    .savedWdata(savedWdata), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .pcOut(pcOut), .statRdata(statRdata), .savedRdata(savedRdata),
    .curMode(curMode)
  );
endmodule

// File: rtl/bankrf_checker.sv
module bankrf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        rdIdxA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [3:0]        rdIdxB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [3:0]        wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic              userBank,
  input logic              pcWe,
  input logic [DATA_W-1:0] pcWdata,
  input logic [DATA_W-1:0] pcOut,
  input logic              statWe,
  input logic [DATA_W-1:0] statWdata,
  input logic [DATA_W-1:0] statRdata,
  input logic [DATA_W-1:0] savedRdata,
  input logic [2:0]        curMode
);
  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == 4'd15 && !pcWe) |=> $stable(pcOut));

  // R8
  pc_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcWe |=> pcOut == $past(pcWdata));

  // R2
  stat_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    statWe |=> (statRdata == $past(statWdata) && curMode == $past(statWdata[2:0])));

  // R6
  no_saved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == 3'd0 || curMode >= 3'd6) |-> savedRdata == '0);

  // R9
  write_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx != 4'd15 && !statWe) |=>
      ((rdIdxA == $past(wrIdx) && userBank == $past(userBank)) ? rdDataA == $past(wrData) : 1'b1));

  // R10
  ports_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxA == rdIdxB) |-> rdDataA == rdDataB);
endmodule

bind bankedRegFile bankrf_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB),
  .rdDataB(rdDataB), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
  .userBank(userBank), .pcWe(pcWe), .pcWdata(pcWdata), .pcOut(pcOut),
  .statWe(statWe), .statWdata(statWdata), .statRdata(statRdata),
  .savedRdata(savedRdata), .curMode(curMode)
);

// File: tb/bankedRegFile_tb_top.sv
module bankedRegFile_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic [31:0] rdDataA, rdDataB, pcOut, statRdata, savedRdata;
  logic        wrEn = 1'b0, userBank = 1'b0, pcWe = 1'b0, statWe = 1'b0, savedWe = 1'b0;
  logic [31:0] wrData = '0, pcWdata = '0, statWdata = '0, savedWdata = '0;
  logic [2:0]  curMode;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bankedRegFile dut_i (
    .clk(clk), .rstN(rstN), .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB),
    .rdDataB(rdDataB), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .userBank(userBank), .pcWe(pcWe), .pcWdata(pcWdata), .pcOut(pcOut),
    .statWe(statWe), .statWdata(statWdata), .statRdata(statRdata),
    .savedWe(savedWe), .savedWdata(savedWdata), .savedRdata(savedRdata),
    .curMode(curMode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrIdx = idx; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic setMode(input logic [2:0] m);
    @(negedge clk); statWe = 1'b1; statWdata = {29'd0, m};
    @(negedge clk); statWe = 1'b0;
  endtask

  task automatic wrSaved(input logic [31:0] d);
    @(negedge clk); savedWe = 1'b1; savedWdata = d;
    @(negedge clk); savedWe = 1'b0;
  endtask

  task automatic readA(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk); rdIdxA = idx; #1; d = rdDataA;
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      readA(4'(i), d);
      check($sformatf("R1 reset idx %0d", i), d, 32'h0);
    end
    check("R1 reset status", statRdata, 32'h3);
    check("R1 reset saved", savedRdata, 32'h0);
    check("R1 reset pc", pcOut, 32'h0);
  endtask

  task automatic testShared();
    logic [31:0] d;
    setMode(3'd3); wrReg(4'd3, 32'h0000_3333);
    setMode(3'd4); readA(4'd3, d); check("R3 r3 from abort", d, 32'h0000_3333);
    setMode(3'd1); wrReg(4'd7, 32'h0000_7777);
    setMode(3'd0); readA(4'd7, d); check("R3 r7 from user", d, 32'h0000_7777);
  endtask

  task automatic testBanked();
    logic [31:0] d;
    for (int m = 0; m < 6; m++) begin
      setMode(3'(m));
      wrReg(4'd13, 32'h0000_D000 + 32'(m));
      wrReg(4'd14, 32'h0000_E000 + 32'(m));
    end
    for (int m = 0; m < 6; m++) begin
      setMode(3'(m));
      readA(4'd13, d); check($sformatf("R4 sp mode %0d", m), d, 32'h0000_D000 + 32'(m));
      readA(4'd14, d); check($sformatf("R4 lr mode %0d", m), d, 32'h0000_E000 + 32'(m));
    end
    setMode(3'd6);
    readA(4'd13, d); check("R4 system sp is user copy", d, 32'h0000_D000);
  endtask

  task automatic testFast();
    logic [31:0] d;
    setMode(3'd0);
    for (int i = 8; i <= 12; i++) wrReg(4'(i), 32'h0000_0800 + 32'(i));
    setMode(3'd1);
    for (int i = 8; i <= 12; i++) wrReg(4'(i), 32'h0000_0F80 + 32'(i));
    setMode(3'd2); readA(4'd8, d);  check("R5 irq r8 user copy", d, 32'h0000_0808);
    setMode(3'd1); readA(4'd10, d); check("R5 fast r10 private", d, 32'h0000_0F8A);
    readA(4'd12, d); check("R5 fast r12 private", d, 32'h0000_0F8C);
  endtask

  task automatic testSaved();
    for (int m = 1; m <= 5; m++) begin
      setMode(3'(m)); wrSaved(32'h0000_5A00 + 32'(m));
    end
    for (int m = 1; m <= 5; m++) begin
      setMode(3'(m)); #1;
      check($sformatf("R6 saved mode %0d", m), savedRdata, 32'h0000_5A00 + 32'(m));
    end
    setMode(3'd0); wrSaved(32'hDEAD_BEEF); #1;
    check("R6 user saved reads zero", savedRdata, 32'h0);
    setMode(3'd6); wrSaved(32'hDEAD_BEEF); #1;
    check("R6 system saved reads zero", savedRdata, 32'h0);
    for (int m = 1; m <= 5; m++) begin
      setMode(3'(m)); #1;
      check($sformatf("R6 saved mode %0d untouched", m), savedRdata, 32'h0000_5A00 + 32'(m));
    end
  endtask

  task automatic testOverride();
    logic [31:0] d;
    setMode(3'd1);
    @(negedge clk); userBank = 1'b1;
    readA(4'd8, d);  check("R7 override r8", d, 32'h0000_0808);
    readA(4'd13, d); check("R7 override r13", d, 32'h0000_D000);
    wrReg(4'd9, 32'h0000_1234);
    @(negedge clk); userBank = 1'b0;
    readA(4'd9, d); check("R7 fast r9 kept", d, 32'h0000_0F89);
    setMode(3'd0);
    readA(4'd9, d); check("R7 user r9 written", d, 32'h0000_1234);
  endtask

  task automatic testPc();
    logic [31:0] d;
    wrReg(4'd15, 32'h0000_0BAD); #1;
    check("R8 general write to pc ignored", pcOut, 32'h0);
    @(negedge clk); pcWe = 1'b1; pcWdata = 32'h0000_0100;
    @(negedge clk); pcWe = 1'b0;
    check("R8 pc port load", pcOut, 32'h0000_0100);
    readA(4'd15, d); check("R8 index 15 reads pc", d, 32'h0000_0100);
  endtask

  task automatic testRdw();
    wrReg(4'd2, 32'h0000_1111);
    @(negedge clk); wrEn = 1'b1; wrIdx = 4'd2; wrData = 32'h0000_2222; rdIdxA = 4'd2; #1;
    check("R9 old value same cycle", rdDataA, 32'h0000_1111);
    @(posedge clk); #1;
    check("R9 new value after edge", rdDataA, 32'h0000_2222);
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic testDual();
    @(negedge clk); rdIdxA = 4'd3; rdIdxB = 4'd7; #1;
    check("R10 port A", rdDataA, 32'h0000_3333);
    check("R10 port B", rdDataB, 32'h0000_7777);
    @(negedge clk); rdIdxB = 4'd3; #1;
    check("R10 equal indices", rdDataB, rdDataA);
  endtask

  task automatic testReserved();
    logic [31:0] d;
    setMode(3'd7); #1;
    check("R2 curMode reserved", 32'(curMode), 32'd7);
    readA(4'd13, d); check("R11 reserved sp", d, 32'h0000_D000);
    readA(4'd8, d);  check("R11 reserved r8", d, 32'h0000_0808);
    check("R11 reserved saved zero", savedRdata, 32'h0);
    @(negedge clk); statWe = 1'b1; statWdata = 32'hF000_0004;
    @(negedge clk); statWe = 1'b0;
    check("R2 status word", statRdata, 32'hF000_0004);
    check("R2 curMode abort", 32'(curMode), 32'd4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testShared();
    testBanked();
    testFast();
    testSaved();
    testOverride();
    testPc();
    testRdw();
    testDual();
    testReserved();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule